// File: doc/BRIEF.md
# PHY Management Register Autoscan Engine

This block keeps a local mirror of the management registers of up to four external PHYs. While scanning is enabled it reads every register, addresses 0 through 31, of each PHY in use. It repeats this without end and stores each result in a shadow register file that holds one bank per MAC port. All bus traffic goes through a separate serial management master, reached through a request/acknowledge interface that carries one transaction at a time.

A 32-bit address mask selects the PHYs to scan. The set bits are taken in order of rising bit index, and each one is assigned to the next free MAC port. A host CPU can also issue its own PHY reads and writes through the block. Such an access waits only for the scan read in progress to finish, and it runs before any further scan read. Scanning then picks up at the register after the last one it completed. The host reads the mirrored values through a combinational lookup port indexed by port and register.

Top module: `phy_autoscan`

## Requirements
- R1: After reset, `md_req` and `cpu_done` are low and every shadow entry reads as zero.
- R2: Scan transactions are issued only while `scan_enable` is high and `phy_mask` has at least one set bit. With an all-zero mask no scan request appears, and CPU accesses are still served.
- R3: The set bit of `phy_mask` with the lowest index is the PHY address of port 0, the next set bit is port 1, and so on. Set bits beyond the fourth are never scanned.
- R4: Scan transactions are reads (`md_we` = 0). They cover registers 0 to 31 of one port in ascending order, then move to the next port. After the highest enabled port the scan wraps to port 0.
- R5: Once `md_req` is raised, it stays high with `md_we`, `md_phy`, `md_reg` and `md_wdata` unchanged until the cycle in which `md_ack` is high. That cycle completes the transaction.
- R6: When a scan read is acknowledged, `md_rdata` is written into the shadow entry for that port and register. It can then be read on `sh_data`, selected combinationally by `sh_port` and `sh_reg`.
- R7: A pending `cpu_req` is served before any further scan read. At most one scan acknowledge, the read already in flight, occurs between the rise of `cpu_req` and `cpu_done`.
- R8: After a CPU access, or after scanning is disabled and enabled again, the scan continues with the register following the last completed scan read. If the stored port index is not below the number of enabled ports, the scan resumes at port 0 with the stored register.
- R9: `cpu_done` is high exactly in the acknowledge cycle of a CPU transaction. For a read, `cpu_rdata` carries the returned data in that cycle.
- R10: A CPU write does not change the shadow. The new value appears only after that register is next scanned.
- R11: When `scan_enable` falls, a scan read in flight completes and no new scan request follows. The shadow contents are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_enable | input | 1 | Background scan enable |
| phy_mask | input | 32 | PHY address enable mask |
| cpu_req | input | 1 | CPU access request, held until `cpu_done` |
| cpu_we | input | 1 | CPU access is a write |
| cpu_phy | input | 5 | CPU target PHY address |
| cpu_reg | input | 5 | CPU target register address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_done | output | 1 | CPU access completed |
| cpu_rdata | output | 16 | CPU read data, valid with `cpu_done` |
| md_req | output | 1 | Management transaction request |
| md_we | output | 1 | Transaction is a write |
| md_phy | output | 5 | Transaction PHY address |
| md_reg | output | 5 | Transaction register address |
| md_wdata | output | 16 | Transaction write data |
| md_ack | input | 1 | Transaction complete, one cycle |
| md_rdata | input | 16 | Read data, valid with `md_ack` |
| sh_port | input | 2 | Shadow read port index |
| sh_reg | input | 5 | Shadow read register index |
| sh_data | output | 16 | Shadow read data |

## Verification
The bench raises a CPU request while a scan read is in flight. A design without proper preemption would either abort that read or let more scan reads slip in ahead of the CPU. After the access it checks that the next scan read is the successor of the last one. A design that restarts the scan would jump back to register 0 of port 0. It also issues a CPU write to a register the scan has not yet reached and checks that the shadow keeps its old value until the scan passes that register. Other masks exercise a six-bit mask, where a design that miscounts would scan a fifth PHY, and a single-bit mask, where the scan must wrap on the same PHY. An empty mask must produce no scan traffic at all. Re-enabling with fewer ports than the stored index must restart at port 0.

// File: rtl/autoscan_pkg.sv
package autoscan_pkg;
  localparam int PORTS  = 4;
  localparam int PORT_W = $clog2(PORTS);
  localparam int CNT_W  = $clog2(PORTS + 1);
  localparam int AW     = 5;
  localparam int REGS   = 1 << AW;
  localparam int MASK_W = 1 << AW;
  localparam int DW     = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_CPU} arb_state_t;

  // Address of the k-th set bit of the mask, counted from bit 0.
  function automatic logic [AW-1:0] slot_addr(input logic [MASK_W-1:0] m, input int k);
    int seen;
    slot_addr = '0;
    seen = 0;
    for (int i = 0; i < MASK_W; i++) begin
      if (m[i]) begin
        if (seen == k) slot_addr = AW'(i);
        seen++;
      end
    end
  endfunction

  // Number of usable ports: set bits, saturated at PORTS.
  function automatic logic [CNT_W-1:0] slot_count(input logic [MASK_W-1:0] m);
    int n;
    n = 0;
    for (int i = 0; i < MASK_W; i++)
      if (m[i] && n < PORTS) n++;
    return CNT_W'(n);
  endfunction

  // Port that follows p in a ring of n ports.
  function automatic logic [PORT_W-1:0] next_port(input logic [PORT_W-1:0] p,
                                                  input logic [CNT_W-1:0] n);
    if (CNT_W'(p) + CNT_W'(1) >= n) return '0;
    return p + PORT_W'(1);
  endfunction
endpackage

// File: rtl/scan_map.sv
module scan_map
  import autoscan_pkg::*;
(
  input  logic [MASK_W-1:0]          mask,
  output logic [PORTS-1:0][AW-1:0]   slot_phy,
  output logic [CNT_W-1:0]           slot_cnt
);
  for (genvar g = 0; g < PORTS; g++) begin : g_slot
    assign slot_phy[g] = slot_addr(mask, g);
  end
  assign slot_cnt = slot_count(mask);
endmodule

// File: rtl/scan_pointer.sv
module scan_pointer
  import autoscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [PORT_W-1:0] done_port,
  input  logic [AW-1:0]     done_reg,
  input  logic [CNT_W-1:0]  slot_cnt,
  output logic [PORT_W-1:0] eff_port,
  output logic [AW-1:0]     ptr_reg
);
  logic [PORT_W-1:0] ptr_port;

  assign eff_port = (CNT_W'(ptr_port) < slot_cnt) ? ptr_port : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_port <= '0;
      ptr_reg  <= '0;
    end else if (adv) begin
      ptr_reg  <= done_reg + AW'(1);
      ptr_port <= (done_reg == AW'(REGS - 1)) ? next_port(done_port, slot_cnt) : done_port;
    end
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import autoscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PORT_W-1:0] w_port,
  input  logic [AW-1:0]     w_reg,
  input  logic [DW-1:0]     w_data,
  input  logic [PORT_W-1:0] r_port,
  input  logic [AW-1:0]     r_reg,
  output logic [DW-1:0]     r_data
);
  localparam int DEPTH = PORTS * REGS;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[{w_port, w_reg}] <= w_data;
    end
  end

  assign r_data = mem[{r_port, r_reg}];
endmodule

// File: rtl/phy_autoscan.sv
module phy_autoscan
  import autoscan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_enable,
  input  logic [31:0]       phy_mask,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [4:0]        cpu_phy,
  input  logic [4:0]        cpu_reg,
  input  logic [15:0]       cpu_wdata,
  output logic              cpu_done,
  output logic [15:0]       cpu_rdata,
  output logic              md_req,
  output logic              md_we,
  output logic [4:0]        md_phy,
  output logic [4:0]        md_reg,
  output logic [15:0]       md_wdata,
  input  logic              md_ack,
  input  logic [15:0]       md_rdata,
  input  logic [1:0]        sh_port,
  input  logic [4:0]        sh_reg,
  output logic [15:0]       sh_data
);
  arb_state_t                state;
  logic [PORTS-1:0][AW-1:0]  slot_phy;
  logic [CNT_W-1:0]          slot_cnt;
  logic [PORT_W-1:0]         eff_port;
  logic [PORT_W-1:0]         cur_port;
  logic [AW-1:0]             ptr_reg;

  // Named internal events for the checker.
  logic scan_go;
  logic scan_ack;
  logic cpu_ack;
  logic shadow_we;

  assign scan_go   = scan_enable && (slot_cnt != '0);
  assign scan_ack  = (state == ST_SCAN) && md_ack;
  assign cpu_ack   = (state == ST_CPU) && md_ack;
  assign shadow_we = scan_ack;
  assign cpu_done  = cpu_ack;
  assign cpu_rdata = md_rdata;

  scan_map u_map (
    .mask     (phy_mask),
    .slot_phy (slot_phy),
    .slot_cnt (slot_cnt)
  );

  scan_pointer u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (scan_ack),
    .done_port (cur_port),
    .done_reg  (md_reg),
    .slot_cnt  (slot_cnt),
    .eff_port  (eff_port),
    .ptr_reg   (ptr_reg)
  );

  shadow_bank u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (shadow_we),
    .w_port (cur_port),
    .w_reg  (md_reg),
    .w_data (md_rdata),
    .r_port (sh_port),
    .r_reg  (sh_reg),
    .r_data (sh_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      md_req   <= 1'b0;
      md_we    <= 1'b0;
      md_phy   <= '0;
      md_reg   <= '0;
      md_wdata <= '0;
      cur_port <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cpu_req) begin
            md_req   <= 1'b1;
            md_we    <= cpu_we;
            md_phy   <= cpu_phy;
            md_reg   <= cpu_reg;
            md_wdata <= cpu_wdata;
            state    <= ST_CPU;
          end else if (scan_go) begin
            md_req   <= 1'b1;
            md_we    <= 1'b0;
            md_phy   <= slot_phy[eff_port];
            md_reg   <= ptr_reg;
            md_wdata <= '0;
            cur_port <= eff_port;
            state    <= ST_SCAN;
          end
        end
        ST_SCAN, ST_CPU: begin
          if (md_ack) begin
            md_req <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/autoscan_checker.sv
module autoscan_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        scan_enable,
  input logic [31:0] phy_mask,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic [4:0]  cpu_phy,
  input logic [4:0]  cpu_reg,
  input logic        cpu_done,
  input logic        md_req,
  input logic        md_we,
  input logic [4:0]  md_phy,
  input logic [4:0]  md_reg,
  input logic [15:0] md_wdata,
  input logic        md_ack,
  input logic        shadow_we
);
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (md_req && !md_ack) |=> (md_req && $stable(md_phy) && $stable(md_reg)
                             && $stable(md_we) && $stable(md_wdata)));

  p_start_allowed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(md_req) |-> ($past(cpu_req) || ($past(scan_enable) && $past(phy_mask) != 32'h0)));

  p_cpu_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(md_req) && $past(cpu_req)) |->
      (md_phy == $past(cpu_phy) && md_reg == $past(cpu_reg) && md_we == $past(cpu_we)));

  p_scan_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(md_req) && !$past(cpu_req)) |-> !md_we);

  p_done_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> (md_ack && md_req));

  p_shadow_scan_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_we |-> (md_ack && !cpu_done && !md_we));
endmodule

bind phy_autoscan autoscan_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scan_enable (scan_enable),
  .phy_mask    (phy_mask),
  .cpu_req     (cpu_req),
  .cpu_we      (cpu_we),
  .cpu_phy     (cpu_phy),
  .cpu_reg     (cpu_reg),
  .cpu_done    (cpu_done),
  .md_req      (md_req),
  .md_we       (md_we),
  .md_phy      (md_phy),
  .md_reg      (md_reg),
  .md_wdata    (md_wdata),
  .md_ack      (md_ack),
  .shadow_we   (shadow_we)
);

// File: tb/phy_autoscan_test.sv
module phy_autoscan_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_enable = 1'b0;
  logic [31:0] phy_mask = 32'h0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [4:0]  cpu_phy = '0;
  logic [4:0]  cpu_reg = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_done;
  logic [15:0] cpu_rdata;
  logic        md_req, md_we;
  logic [4:0]  md_phy, md_reg;
  logic [15:0] md_wdata;
  logic        md_ack;
  logic [15:0] md_rdata;
  logic [1:0]  sh_port = '0;
  logic [4:0]  sh_reg = '0;
  logic [15:0] sh_data;

  always #(CLK_P/2) clk = ~clk;

  phy_autoscan uut (
    .clk(clk), .rst_n(rst_n), .scan_enable(scan_enable), .phy_mask(phy_mask),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_phy(cpu_phy), .cpu_reg(cpu_reg),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .md_req(md_req), .md_we(md_we), .md_phy(md_phy), .md_reg(md_reg),
    .md_wdata(md_wdata), .md_ack(md_ack), .md_rdata(md_rdata),
    .sh_port(sh_port), .sh_reg(sh_reg), .sh_data(sh_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] init_val(input int p, input int r);
    return {p[4:0], r[4:0], 6'b100111};
  endfunction

  // Bench's own view of the mask: position of the k-th set bit, scanning upward.
  function automatic int bslot(input logic [31:0] m, input int k);
    int hit = -1;
    int b = 0;
    while (b < 32) begin
      if (m[b]) begin
        hit++;
        if (hit == k) return b;
      end
      b++;
    end
    return -1;
  endfunction

  function automatic int bcount(input logic [31:0] m);
    int c = $countones(m);
    return (c > 4) ? 4 : c;
  endfunction

  // Management bus model: PHY register storage, ack two cycles after request.
  logic [15:0] mem [32][32];
  int lat;
  always @(posedge clk) begin
    if (!rst_n) begin
      md_ack   <= 1'b0;
      md_rdata <= '0;
      lat      <= 0;
      for (int p = 0; p < 32; p++)
        for (int r = 0; r < 32; r++) mem[p][r] <= init_val(p, r);
    end else if (md_req && !md_ack) begin
      if (lat == 2) begin
        md_ack   <= 1'b1;
        md_rdata <= md_we ? 16'h0 : mem[md_phy][md_reg];
        if (md_we) mem[md_phy][md_reg] <= md_wdata;
        lat <= 0;
      end else begin
        lat <= lat + 1;
      end
    end else begin
      md_ack <= 1'b0;
    end
  end

  // Scoreboard state
  typedef struct packed {
    logic        we;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] d;
  } cpu_item_t;
  cpu_item_t cpu_q[$];

  int exp_port = 0;
  int exp_reg  = 0;
  int last_port = -1;
  int last_reg  = -1;
  int scan_total = 0;
  int scans_in_cpu = 0;

  // Monitor: every acknowledge is compared with the bench's prediction.
  always @(negedge clk) begin
    if (rst_n && md_ack) begin
      if (cpu_done) begin
        if (cpu_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected cpu_done", 32'h1, 32'h0);
        end else begin
          cpu_item_t it;
          it = cpu_q.pop_front();
          chk(md_phy == it.phy && md_reg == it.rg && md_we == it.we, "R7",
              "cpu transaction fields", {21'h0, md_we, md_phy, md_reg},
              {21'h0, it.we, it.phy, it.rg});
          if (!it.we)
            chk(cpu_rdata == it.d, "R9", "cpu read data", {16'h0, cpu_rdata}, {16'h0, it.d});
          chk(scans_in_cpu <= 1, "R7", "scan acks while cpu pending", scans_in_cpu, 1);
        end
      end else begin
        int ep;
        ep = bslot(phy_mask, exp_port);
        chk(md_we == 1'b0, "R4", "scan is a read", {31'h0, md_we}, 32'h0);
        chk(md_phy == ep[4:0] && md_reg == exp_reg[4:0], "R3 R4 R8",
            "scan address {phy,reg}", {22'h0, md_phy, md_reg},
            {22'h0, ep[4:0], exp_reg[4:0]});
        last_port = exp_port;
        last_reg  = exp_reg;
        if (exp_reg == 31) begin
          exp_reg  = 0;
          exp_port = (exp_port + 1 >= bcount(phy_mask)) ? 0 : exp_port + 1;
        end else begin
          exp_reg = exp_reg + 1;
        end
        if (cpu_req) scans_in_cpu++;
        scan_total++;
      end
    end
  end

  task automatic wait_scans(input int n);
    int target = scan_total + n;
    while (scan_total < target) @(negedge clk);
  endtask

  task automatic read_sh(input int p, input int r, output logic [15:0] v);
    @(negedge clk);
    sh_port = p[1:0];
    sh_reg  = r[4:0];
    #1;
    v = sh_data;
  endtask

  task automatic check_bank(input int nports, input string req);
    logic [15:0] v;
    int bad = 0;
    for (int p = 0; p < nports; p++) begin
      for (int r = 0; r < 32; r++) begin
        int ph = bslot(phy_mask, p);
        read_sh(p, r, v);
        if (v !== mem[ph][r]) begin
          bad++;
          chk(1'b0, req, "shadow entry", {16'h0, v}, {16'h0, mem[ph][r]});
        end
      end
    end
    if (bad == 0) chk(1'b1, req, "shadow bank", 0, 0);
  endtask

  task automatic cpu_access(input logic we, input int phy, input int rg, input logic [15:0] d);
    cpu_item_t it;
    it.we = we; it.phy = phy[4:0]; it.rg = rg[4:0];
    it.d = we ? d : mem[phy][rg];
    cpu_q.push_back(it);
    @(posedge clk); #1;
    scans_in_cpu = 0;
    cpu_we = we; cpu_phy = phy[4:0]; cpu_reg = rg[4:0]; cpu_wdata = d;
    cpu_req = 1'b1;
    while (1) begin
      @(negedge clk);
      if (cpu_done) break;
    end
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  task automatic stop_scan();
    @(posedge clk); #1;
    scan_enable = 1'b0;
    while (md_req) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic quiet_window(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (md_req) seen++;
    end
    chk(seen == 0, req, "no request in quiet window", seen, 0);
  endtask

  bit wd_hit = 0;
  initial begin
    #(CLK_P * 150000);
    wd_hit = 1;
    chk(1'b0, "WATCHDOG", "run timed out", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(md_req == 1'b0, "R1", "md_req after reset", {31'h0, md_req}, 0);
    chk(cpu_done == 1'b0, "R1", "cpu_done after reset", {31'h0, cpu_done}, 0);
    for (int p = 0; p < 4; p++) begin
      read_sh(p, 0, v);
      chk(v == 16'h0, "R1", "shadow reg0 after reset", {16'h0, v}, 0);
      read_sh(p, 31, v);
      chk(v == 16'h0, "R1", "shadow reg31 after reset", {16'h0, v}, 0);
    end

    // R3 R4 R6: three PHYs, scan wraps back to port 0
    phy_mask = (32'h1 << 3) | (32'h1 << 7) | (32'h1 << 20);
    exp_port = 0; exp_reg = 0;
    @(posedge clk); #1 scan_enable = 1'b1;
    wait_scans(3 * 32 + 8);
    check_bank(3, "R6");
    read_sh(3, 4, v);
    chk(v == 16'h0, "R3", "unused port bank untouched", {16'h0, v}, 0);

    // R11: disable lets the read finish, then silence; shadow kept
    stop_scan();
    quiet_window(40, "R11");
    read_sh(1, 9, v);
    chk(v == init_val(7, 9), "R11", "shadow kept after disable", {16'h0, v},
        {16'h0, init_val(7, 9)});

    // R3: six set bits, only the lowest four are scanned (phys 0,8,9,10)
    phy_mask = 32'h8000_0F01;
    @(posedge clk); #1 scan_enable = 1'b1;
    wait_scans(4 * 32 + 8);
    check_bank(4, "R3");

    // R7 R8 R10: CPU write preempts mid-scan; shadow not touched by it
    while (!(last_port == 0 && last_reg == 10)) @(negedge clk);
    cpu_access(1'b1, 8, 5, 16'hBEEF);
    read_sh(1, 5, v);
    chk(v == init_val(8, 5), "R10", "shadow unchanged after cpu write", {16'h0, v},
        {16'h0, init_val(8, 5)});
    wait_scans(50);
    read_sh(1, 5, v);
    chk(v == 16'hBEEF, "R10", "shadow updated by later scan", {16'h0, v}, 32'hBEEF);
    cpu_access(1'b0, 9, 2, 16'h0);

    // R2: empty mask with enable set -> no scan; CPU still served
    stop_scan();
    phy_mask = 32'h0;
    @(posedge clk); #1 scan_enable = 1'b1;
    quiet_window(40, "R2");
    cpu_access(1'b0, 31, 0, 16'h0);
    quiet_window(20, "R2");

    // R8: one PHY only; stored port index beyond count resumes at port 0
    stop_scan();
    phy_mask = 32'h1 << 31;
    if (exp_port >= 1) exp_port = 0;
    @(posedge clk); #1 scan_enable = 1'b1;
    wait_scans(40);
    stop_scan();

    if (!wd_hit) begin
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule